// File: doc/BRIEF.md
# HDLC Transmit Framer with Flag Fill

This block turns a byte stream into a bit-serial HDLC line signal. Payload bytes arrive on a valid/ready/last interface that runs in the transmitter's own clock domain. That clock has no relation to any receive clock. The framer puts an opening flag in front of each frame and a 16-bit frame check sequence and a closing flag behind it. It inserts stuffed zeros so that the payload and the FCS never look like a flag. It moves one bit to the serial output on every rising edge of the transmit clock.

When no frame is waiting, the line carries an unbroken run of flags. The closing flag of one frame also serves as the opening flag of the next frame when that frame is already offered. The source must keep bytes coming within a frame. If the framer asks for a byte in mid-frame and none is offered, it aborts the frame with a run of seven ones and then returns to flags.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While no frame is in progress, `ser_out` carries back-to-back flags, each the bit pattern 0,1,1,1,1,1,1,0, with no zero between them. `in_ready` pulses high for exactly one cycle in every eight.
- R2: Each frame goes out as a flag, then the payload bytes least significant bit first, then two FCS bytes, then a flag.
- R3: The FCS is a CRC with generator x^16 + x^12 + x^5 + 1. It is processed least significant bit first (reflected constant 0x8408), starts from 0xFFFF and covers the payload bits. It is sent complemented, low byte first, each byte least significant bit first.
- R4: Inside the payload and the FCS, a 0 is inserted after every five consecutive 1 bits. This includes a run of ones that ends on the last FCS bit. Flag and abort bits are never stuffed.
- R5: `in_ready` is high only during the cycle in which the last bit of a flag, or of a payload byte that is not the final byte, is being emitted. A byte is taken on a rising edge with `in_ready` and `in_valid` both high. Bit 0 of the first byte of a frame appears on `ser_out` after the next rising edge.
- R6: If `in_valid` is low while `in_ready` is high in mid-frame, the frame is abandoned. The framer sends seven 1 bits and then resumes flags.
- R7: If the first byte of the next frame is offered by the time the closing flag ends, that flag is the only flag between the two frames.
- R8: While `tx_rst_n` is low, `ser_out` is 1 and `in_ready` is 0. The release of the reset is synchronised with two flops, so the first flag bit appears on the third rising edge after `tx_rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit bit clock; `ser_out` changes on its rising edge |
| tx_rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data | input | BYTE_W | Payload byte offered by the source |
| in_valid | input | 1 | `in_data` holds a byte of the current or next frame |
| in_last | input | 1 | The offered byte is the final byte of its frame |
| in_ready | output | 1 | The framer takes the offered byte at this rising edge |
| ser_out | output | 1 | Serial HDLC line output |

## Verification
`ser_out` is a register. Any bit chosen by the sequencer is visible one cycle later, so bit 0 of a first byte is sampled on the falling edge that follows the second rising edge after the handshake. The first flag bit is sampled three rising edges after `tx_rst_n` rises. FCS bytes, stuffed zeros and flags have no fixed cycle position once stuffing shifts them. For that reason, a monitor decodes `ser_out` on every falling edge by removing stuffed zeros and finding flags and aborts. Each frame it recovers is compared with a queue that the driver fills when it offers the frame. The monitor also counts the flags between two back-to-back frames. The strobe `in_ready` is counted over a 64-cycle idle window.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  // Frame sequencer phases
  typedef enum logic [1:0] {
    M_FLAG  = 2'd0,
    M_DATA  = 2'd1,
    M_FCS   = 2'd2,
    M_ABORT = 2'd3
  } tx_mode_t;

  localparam int          CRC_W     = 16;
  localparam logic [7:0]  FLAG_CHAR = 8'h7E;
  localparam logic [CRC_W-1:0] CRC_POLY_R = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_SEED   = 16'hFFFF;

  // One LSB-first CRC step
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic             b);
    logic fb;
    fb = c[0] ^ b;
    crc_step = (c >> 1) ^ (fb ? CRC_POLY_R : '0);
  endfunction

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
  import hdlc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_nxt
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;

  assign crc_nxt = crc_step(crc_q, bit_in);

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = CRC_SEED;
    else if (en) crc_d = crc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  // R3: a new frame always starts from the seed value
  clr_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_q == CRC_SEED));

endmodule

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer #(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_bit,
  input  logic stuffable,
  output logic stuff_now,
  output logic ser_out
);

  localparam int ONES_W = $clog2(STUFF_RUN + 1);
  localparam logic [ONES_W-1:0] RUN_MAX = ONES_W'(STUFF_RUN);

  logic [ONES_W-1:0] ones_q, ones_d;
  logic              ser_q, ser_d;

  assign stuff_now = (ones_q == RUN_MAX);
  assign ser_out   = ser_q;

  always_comb begin
    if (stuff_now) begin
      ser_d  = 1'b0;
      ones_d = '0;
    end else begin
      ser_d  = raw_bit;
      ones_d = (stuffable && raw_bit) ? ones_q + ONES_W'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      ser_q  <= 1'b1;
    end else begin
      ones_q <= ones_d;
      ser_q  <= ser_d;
    end
  end

  // R4
  stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_q == RUN_MAX) |=> !ser_q);

  // R4
  ones_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= RUN_MAX);

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int ABORT_LEN = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              stuff_now,
  input  logic [CRC_W-1:0]  crc_nxt,
  output logic              raw_bit,
  output logic              stuffable,
  output logic              crc_clr,
  output logic              crc_en,
  output logic              abort_active
);

  localparam int SH_W  = (CRC_W > BYTE_W) ? CRC_W : BYTE_W;
  localparam int CNT_W = $clog2(SH_W);
  localparam int FI_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FCS_LAST   = CNT_W'(CRC_W - 1);
  localparam logic [CNT_W-1:0] ABORT_LAST = CNT_W'(ABORT_LEN - 1);

  tx_mode_t          mode_q, mode_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic              last_q, last_d;
  logic              adv;

  assign adv          = !stuff_now;
  assign abort_active = (mode_q == M_ABORT);

  assign in_ready = adv && (cnt_q == BYTE_LAST) &&
                    ((mode_q == M_FLAG) || ((mode_q == M_DATA) && !last_q));

  always_comb begin
    mode_d    = mode_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    last_d    = last_q;
    raw_bit   = 1'b1;
    stuffable = 1'b0;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    unique case (mode_q)
      M_FLAG: begin
        raw_bit = FLAG_CHAR[cnt_q[FI_W-1:0]];
        if (adv) begin
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == BYTE_LAST) begin
            cnt_d = '0;
            if (in_valid) begin
              mode_d  = M_DATA;
              sh_d    = SH_W'(in_data);
              last_d  = in_last;
              crc_clr = 1'b1;
            end
          end
        end
      end
      M_DATA: begin
        raw_bit   = sh_q[0];
        stuffable = 1'b1;
        if (adv) begin
          crc_en = 1'b1;
          sh_d   = sh_q >> 1;
          cnt_d  = cnt_q + CNT_W'(1);
          if (cnt_q == BYTE_LAST) begin
            cnt_d = '0;
            if (last_q) begin
              mode_d = M_FCS;
              sh_d   = SH_W'(~crc_nxt);
            end else if (in_valid) begin
              sh_d   = SH_W'(in_data);
              last_d = in_last;
            end else begin
              mode_d = M_ABORT;
            end
          end
        end
      end
      M_FCS: begin
        raw_bit   = sh_q[0];
        stuffable = 1'b1;
        if (adv) begin
          sh_d  = sh_q >> 1;
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == FCS_LAST) begin
            cnt_d  = '0;
            mode_d = M_FLAG;
          end
        end
      end
      M_ABORT: begin
        raw_bit = 1'b1;
        if (adv) begin
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == ABORT_LAST) begin
            cnt_d  = '0;
            mode_d = M_FLAG;
          end
        end
      end
      default: mode_d = M_FLAG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_FLAG;
      cnt_q  <= '0;
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      last_q <= last_d;
    end
  end

  // R5
  byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> (mode_q == M_DATA && cnt_q == '0));

  // R6
  abort_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DATA && in_ready && !in_valid) |=> (mode_q == M_ABORT));

  // R3
  fcs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FLAG && $past(mode_q) == M_FCS) |-> ($past(cnt_q) == FCS_LAST));

  // R2
  closing_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FCS && cnt_q == FCS_LAST && adv) |=> (mode_q == M_FLAG && cnt_q == '0));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 5,
  parameter int ABORT_LEN = 7
) (
  input  logic              tx_clk,
  input  logic              tx_rst_n,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              ser_out
);

  logic [1:0]       rst_pipe;
  logic             rst_s_n;
  logic             raw_bit, stuffable, stuff_now;
  logic             crc_clr, crc_en, abort_active;
  logic [CRC_W-1:0] crc_nxt;

  // asynchronous assert, synchronous release
  always_ff @(posedge tx_clk or negedge tx_rst_n) begin
    if (!tx_rst_n) rst_pipe <= 2'b00;
    else           rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  hdlc_tx_seq #(.BYTE_W(BYTE_W), .ABORT_LEN(ABORT_LEN)) seq_i (
    .clk          (tx_clk),
    .rst_n        (rst_s_n),
    .in_data      (in_data),
    .in_valid     (in_valid),
    .in_last      (in_last),
    .in_ready     (in_ready),
    .stuff_now    (stuff_now),
    .crc_nxt      (crc_nxt),
    .raw_bit      (raw_bit),
    .stuffable    (stuffable),
    .crc_clr      (crc_clr),
    .crc_en       (crc_en),
    .abort_active (abort_active)
  );

  hdlc_tx_crc crc_i (
    .clk     (tx_clk),
    .rst_n   (rst_s_n),
    .clr     (crc_clr),
    .en      (crc_en),
    .bit_in  (raw_bit),
    .crc_nxt (crc_nxt)
  );

  hdlc_tx_stuffer #(.STUFF_RUN(STUFF_RUN)) stuff_i (
    .clk       (tx_clk),
    .rst_n     (rst_s_n),
    .raw_bit   (raw_bit),
    .stuffable (stuffable),
    .stuff_now (stuff_now),
    .ser_out   (ser_out)
  );

  // R6
  abort_ones_chk: assert property (@(posedge tx_clk) disable iff (!rst_s_n)
    (abort_active && !stuff_now) |=> ser_out);

  // R8
  reset_ready_chk: assert property (@(posedge tx_clk)
    !rst_s_n |-> !in_ready);

endmodule

// File: tb/hdlc_tx_framer_tb_top.sv
module hdlc_tx_framer_tb_top;

  logic       clk = 1'b0;
  logic       tx_rst_n;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_last;
  logic       in_ready;
  logic       ser_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  int         exp_len_q[$];
  int         exp_gap_q[$];
  logic [7:0] exp_byte_q[$];
  logic [7:0] txq[$];
  bit         bq[$];
  int         idle_flags = 0;
  int         flags_since = 0;

  always #10 clk = ~clk;

  hdlc_tx_framer dut_i (
    .tx_clk   (clk),
    .tx_rst_n (tx_rst_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .ser_out  (ser_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_fcs();
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < txq.size(); i++)
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = c[0] ^ txq[i][k];
        c  = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  // driver: expectations go to the scoreboard, bytes go to the framer
  task automatic send_frame(input int gap_exp, input bit abort_it, input bit keep_valid);
    int n;
    logic [15:0] f;
    n = txq.size();
    if (abort_it) begin
      exp_len_q.push_back(-1);
    end else begin
      f = ref_fcs();
      exp_len_q.push_back(n + 2);
      foreach (txq[i]) exp_byte_q.push_back(txq[i]);
      exp_byte_q.push_back(f[7:0]);
      exp_byte_q.push_back(f[15:8]);
    end
    exp_gap_q.push_back(gap_exp);
    for (int i = 0; i < n; i++) begin
      in_data  = txq[i];
      in_valid = 1'b1;
      in_last  = (i == n - 1) && !abort_it;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      if (i == 0) begin
        @(posedge clk);
        @(negedge clk);
        // R5: bit 0 of the first byte one edge after acceptance
        check(ser_out == txq[0][0], "R5 first bit timing", ser_out, txq[0][0]);
      end else begin
        @(negedge clk);
      end
    end
    if (abort_it || !keep_valid) begin
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  task automatic flag_seen(inout bit synced, inout bit aborted);
    int rm;
    rm = (bq.size() < 6) ? bq.size() : 6;
    for (int i = 0; i < rm; i++) void'(bq.pop_back());
    if (!synced) begin
      synced = 1;
      aborted = 0;
      bq.delete();
      return;
    end
    if (aborted) begin
      aborted = 0;
      bq.delete();
      flags_since = 0;
      if (exp_len_q.size() == 0) begin
        check(0, "R6 unexpected abort", 0, 0);
      end else begin
        int el;
        el = exp_len_q.pop_front();
        void'(exp_gap_q.pop_front());
        check(el == -1, "R6 abort seen", -1, el);
      end
    end else if (bq.size() == 0) begin
      idle_flags++;
      flags_since++;
    end else begin
      int nb;
      int el;
      int eg;
      bit ok;
      nb = bq.size() / 8;
      if (exp_len_q.size() == 0) begin
        check(0, "R2 unexpected frame", nb, 0);
      end else begin
        el = exp_len_q.pop_front();
        eg = exp_gap_q.pop_front();
        check((bq.size() % 8 == 0) && (nb == el), "R2 frame length", bq.size(), el * 8);
        if (el > 0) begin
          ok = 1;
          for (int i = 0; i < el; i++) begin
            logic [7:0] got;
            logic [7:0] want;
            want = exp_byte_q.pop_front();
            got = '0;
            for (int k = 0; k < 8; k++)
              if (i * 8 + k < bq.size()) got[k] = bq[i * 8 + k];
            if (got !== want) begin
              ok = 0;
              $display("FAIL R3/R4 byte %0d: actual=%0h expected=%0h", i, got, want);
            end
          end
          n_checks++;
          if (!ok) n_errors++;
        end
        if (eg >= 0) check(flags_since == eg, "R7 shared flag", flags_since, eg);
      end
      bq.delete();
      flags_since = 0;
    end
  endtask

  // monitor: destuff and deframe the serial line
  initial begin : mon
    int ones;
    bit synced;
    bit aborted;
    ones = 0;
    synced = 0;
    aborted = 0;
    wait (tx_rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (ser_out) begin
        ones++;
        if (ones <= 5) bq.push_back(1'b1);
        if (ones == 7 && synced) begin
          aborted = 1;
          bq.delete();
        end
      end else begin
        if (ones == 6) flag_seen(synced, aborted);
        else if (ones != 5) bq.push_back(1'b0);
        ones = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    int rdy;
    logic [7:0] lf;
    tx_rst_n = 1'b0;
    in_data  = '0;
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (4) @(negedge clk);
    // R8
    check(ser_out == 1'b1, "R8 reset ser_out", ser_out, 1);
    check(in_ready == 1'b0, "R8 reset in_ready", in_ready, 0);
    tx_rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(ser_out == 1'b1, "R8 line held after second edge", ser_out, 1);
    @(negedge clk);
    check(ser_out == 1'b0, "R8 first flag bit at third edge", ser_out, 0);

    // R1: idle fill
    repeat (8) @(negedge clk);
    rdy = 0;
    idle_flags = 0;
    for (int c = 0; c < 64; c++) begin
      if (in_ready) rdy++;
      @(negedge clk);
    end
    check(rdy == 8, "R1 idle ready strobes", rdy, 8);
    check(idle_flags >= 7, "R1 idle flags", idle_flags, 7);

    // R2/R3: single byte
    txq = '{8'hA5};
    send_frame(-1, 0, 0);
    repeat (40) @(negedge clk);
    // R4: long runs of ones
    txq = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
    send_frame(-1, 0, 0);
    repeat (30) @(negedge clk);
    // R4 flag-like bytes, then R7 back-to-back
    txq = '{8'h7E, 8'h7E, 8'h3F, 8'hF8};
    send_frame(-1, 0, 1);
    txq = '{8'h01, 8'h02, 8'h03};
    send_frame(0, 0, 0);
    repeat (30) @(negedge clk);
    // R6: abort when the source stalls
    txq = '{8'h11, 8'h22, 8'h33};
    send_frame(-1, 1, 0);
    repeat (40) @(negedge clk);
    txq = '{8'hC3, 8'h5A, 8'hFF, 8'h00, 8'h81};
    send_frame(-1, 0, 0);
    repeat (20) @(negedge clk);
    // longer computed payload, then R7 again
    txq.delete();
    lf = 8'h5D;
    for (int i = 0; i < 20; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      txq.push_back(lf);
    end
    send_frame(-1, 0, 1);
    txq = '{8'hFC};
    send_frame(0, 0, 0);

    for (int w = 0; w < 2000 && exp_len_q.size() != 0; w++) @(negedge clk);
    check(exp_len_q.size() == 0, "R2 all frames delivered", exp_len_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule